// File: doc/BRIEF.md
# Preamplifier Reset and Calibration Strobe Controller

This block produces the reset pulses that clear a bank of charge preamplifiers, and the strobe that marks a calibration charge injection. A reset pulse has a fixed width. It can come from a free-running internal timer, whose period is picked by a 2-bit rate code, or from an external request line. Requests that overlap are merged, so one pulse results.

Calibration takes two steps. First, with calibration enabled, a single arm pulse is given. The next accepted preamp reset then carries a one-cycle discharge strobe, and the arm is spent. An arm therefore yields exactly one strobe, and a reset that arrives while calibration is disabled or unarmed gives none.

Top module: `preamp_rst_ctrl`

## Requirements
- R1: While `int_rst_en` is 0 the internal timer produces no reset and stays cleared. After `int_rst_en` rises, the first internal reset is accepted on the P-th consecutive enabled clock edge.
- R2: With `int_rst_en` held at 1 and `rate_sel` constant, internal resets are accepted every P clocks, where P = 2^(BASE_LOG2 + STEP_LOG2*rate_sel). `rate_sel` 0 is the shortest period and 3 the longest. With the default parameters this gives 4096, 16384, 65536 and 262144 clocks.
- R3: An accepted request drives `preamp_rst` high for exactly PULSE_W clocks (8 by default). The pulse starts in the cycle that follows the accepting edge.
- R4: `ext_rst_req` is sampled on each clock edge. A high sample starts a reset pulse whatever the value of `int_rst_en`.
- R5: A request, internal or external, that is sampled while `preamp_rst` is high is ignored, and the pulse in progress is not extended. An internal and an external request on the same edge produce one pulse.
- R6: `cal_dis` is high for one cycle, in the first cycle of a reset pulse, only when `cal_en` is 1 and an arm was taken on an earlier edge. An arm that coincides with the accepting edge counts toward the next pulse.
- R7: Each arm yields exactly one `cal_dis` strobe, and the arm is cleared by that strobe. Further arm pulses given while already armed do not accumulate.
- R8: An edge with `cal_en` at 0 clears a pending arm, and `cal_arm` pulses sampled while `cal_en` is 0 are ignored.
- R9: A synchronous active-high `rst` drives both outputs low, clears the timer and drops any pending arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| int_rst_en | input | 1 | Enables the periodic internal reset timer |
| rate_sel | input | 2 | Internal reset period code |
| ext_rst_req | input | 1 | External reset request, sampled each clock |
| cal_en | input | 1 | Calibration enable |
| cal_arm | input | 1 | Calibration arm request |
| preamp_rst | output | 1 | Registered preamp reset pulse |
| cal_dis | output | 1 | Registered one-cycle calibration discharge strobe |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `rate_sel` changes only while `int_rst_en` is low. A change made while the timer is running triggers the "count reached or passed" rule, and that moves the next reset away from a whole-period boundary. The stimulus follows both rules: it changes `rate_sel` only in disabled stretches, and it drives every input on the falling edge. The internal periods are made short through the parameters so that each rate code runs for several periods.

// File: rtl/preamp_rst_pkg.sv
package preamp_rst_pkg;

  typedef enum logic [1:0] {
    RATE_FASTEST = 2'd0,
    RATE_FAST    = 2'd1,
    RATE_SLOW    = 2'd2,
    RATE_SLOWEST = 2'd3
  } rate_code_e;

  localparam int NUM_RATES = 4;

  function automatic int period_log2(input int base_log2, input int step_log2, input int code);
    return base_log2 + step_log2 * code;
  endfunction

endpackage

// File: rtl/prc_rate_timer.sv
module prc_rate_timer
  import preamp_rst_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int CW = period_log2(BASE_LOG2, STEP_LOG2, NUM_RATES - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_lim
    assign lim[g] = CW'((64'd1 << period_log2(BASE_LOG2, STEP_LOG2, g)) - 64'd1);
  end

  assign tick = en && (cnt >= lim[rate]);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + CW'(1);
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst) !en |=> cnt == '0); // R1
  AST_CNT_BOUND:  assert property (@(posedge clk) disable iff (rst) en && !tick |=> cnt == $past(cnt) + CW'(1)); // R2

endmodule

// File: rtl/prc_pulse_gen.sv
module prc_pulse_gen #(
  parameter int PULSE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic start,
  output logic pulse
);
  localparam int LW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;

  logic [LW-1:0] left;

  assign start = req && !pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      left  <= '0;
    end else if (start) begin
      pulse <= 1'b1;
      left  <= LW'(PULSE_W - 1);
    end else if (pulse) begin
      if (left == '0) pulse <= 1'b0;
      else            left  <= left - LW'(1);
    end
  end

  AST_HOLD_WIDTH:  assert property (@(posedge clk) disable iff (rst) pulse && left != '0 |=> pulse); // R3
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst) pulse && req && left != '0 |=> left == $past(left) - LW'(1)); // R5

endmodule

// File: rtl/prc_cal_seq.sv
module prc_cal_seq (
  input  logic clk,
  input  logic rst,
  input  logic cal_en,
  input  logic cal_arm,
  input  logic start,
  output logic cal_dis
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      cal_dis <= 1'b0;
    end else begin
      cal_dis <= cal_en && armed && start;
      armed   <= cal_en && (cal_arm || (armed && !start));
    end
  end

  AST_DISARM:     assert property (@(posedge clk) disable iff (rst) !cal_en |=> !armed); // R8
  AST_SPENT_ARM:  assert property (@(posedge clk) disable iff (rst) cal_dis && !$past(cal_arm) |-> !armed); // R7

endmodule

// File: rtl/preamp_rst_ctrl.sv
module preamp_rst_ctrl
  import preamp_rst_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 2,
  parameter int PULSE_W   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       int_rst_en,
  input  logic [1:0] rate_sel,
  input  logic       ext_rst_req,
  input  logic       cal_en,
  input  logic       cal_arm,
  output logic       preamp_rst,
  output logic       cal_dis
);
  logic int_tick;
  logic rst_start;

  prc_rate_timer #(
    .BASE_LOG2(BASE_LOG2),
    .STEP_LOG2(STEP_LOG2)
  ) u_timer (
    .clk  (clk),
    .rst  (rst),
    .en   (int_rst_en),
    .rate (rate_sel),
    .tick (int_tick)
  );

  prc_pulse_gen #(
    .PULSE_W(PULSE_W)
  ) u_pulse (
    .clk   (clk),
    .rst   (rst),
    .req   (int_tick || ext_rst_req),
    .start (rst_start),
    .pulse (preamp_rst)
  );

  prc_cal_seq u_cal (
    .clk     (clk),
    .rst     (rst),
    .cal_en  (cal_en),
    .cal_arm (cal_arm),
    .start   (rst_start),
    .cal_dis (cal_dis)
  );

  AST_DIS_ALIGNED:  assert property (@(posedge clk) disable iff (rst) cal_dis |-> $rose(preamp_rst)); // R6
  AST_DIS_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) cal_dis |-> $past(cal_en)); // R6
  AST_DIS_SINGLE:   assert property (@(posedge clk) disable iff (rst) cal_dis |=> !cal_dis); // R7
  AST_RST_SOURCE:   assert property (@(posedge clk) disable iff (rst) $rose(preamp_rst) |-> $past(ext_rst_req) || $past(int_tick)); // R4

endmodule

// File: tb/tb_preamp_rst_ctrl.sv
`timescale 1ns/1ps
module tb_preamp_rst_ctrl;
  localparam int BASE = 4;
  localparam int STEP = 2;
  localparam int WID  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic int_rst_en = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic ext_rst_req = 1'b0;
  logic cal_en = 1'b0;
  logic cal_arm = 1'b0;
  logic preamp_rst, cal_dis;

  always #2.5 clk = ~clk;

  preamp_rst_ctrl #(.BASE_LOG2(BASE), .STEP_LOG2(STEP), .PULSE_W(WID)) dut (
    .clk(clk), .rst(rst), .int_rst_en(int_rst_en), .rate_sel(rate_sel),
    .ext_rst_req(ext_rst_req), .cal_en(cal_en), .cal_arm(cal_arm),
    .preamp_rst(preamp_rst), .cal_dis(cal_dis));

  int checks = 0, fails = 0;
  int run = 0, rem = 0, per;
  bit armed_m = 0, exp_rst = 0, exp_dis = 0, tick_m, req_m, start_m;
  bit prev_rst = 0;
  int npulse = 0, nstrobe = 0;
  string tag = "R9";

  // Behavioural reference model, updated each edge, compared 1 ns later
  always @(posedge clk) begin
    if (rst) begin
      run = 0; rem = 0; armed_m = 0; exp_rst = 0; exp_dis = 0;
    end else begin
      per = 1 << (BASE + STEP * int'(rate_sel));
      tick_m = int_rst_en && (((run + 1) % per) == 0);
      run = int_rst_en ? run + 1 : 0;
      req_m = tick_m || ext_rst_req;
      start_m = (rem == 0) && req_m;
      if (rem > 0) rem--;
      else if (req_m) rem = WID;
      exp_dis = cal_en && armed_m && start_m;
      armed_m = cal_en && (cal_arm || (armed_m && !start_m));
      exp_rst = (rem > 0);
    end
    #1;
    checks++;
    if (preamp_rst !== exp_rst) begin
      fails++;
      $display("FAIL %s preamp_rst got %b expected %b at %0t", tag, preamp_rst, exp_rst, $time);
    end
    checks++;
    if (cal_dis !== exp_dis) begin
      fails++;
      $display("FAIL %s cal_dis got %b expected %b at %0t", tag, cal_dis, exp_dis, $time);
    end
    if (preamp_rst && !prev_rst) npulse++;
    prev_rst = preamp_rst;
    if (cal_dis) nstrobe++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_check(input string t, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", t, what, got, exp);
    end
  endtask

  task automatic clear_counts();
    npulse = 0; nstrobe = 0;
  endtask

  task automatic ext_pulse();
    ext_rst_req = 1'b1; cyc(1); ext_rst_req = 1'b0;
  endtask

  task automatic arm_pulse();
    cal_arm = 1'b1; cyc(1); cal_arm = 1'b0;
  endtask

  initial begin
    // R9: reset state
    cyc(3);
    count_check("R9", "preamp_rst in reset", int'(preamp_rst), 0);
    count_check("R9", "cal_dis in reset", int'(cal_dis), 0);
    rst = 1'b0;

    // R1/R2: each rate code, enabled from a cleared timer
    tag = "R2"; clear_counts(); rate_sel = 2'd0; int_rst_en = 1'b1; cyc(100); int_rst_en = 1'b0; cyc(12);
    count_check("R2", "pulses at code 0 (P=16, 100 edges)", npulse, 6);
    clear_counts(); rate_sel = 2'd1; int_rst_en = 1'b1; cyc(300); int_rst_en = 1'b0; cyc(12);
    count_check("R2", "pulses at code 1 (P=64, 300 edges)", npulse, 4);
    clear_counts(); rate_sel = 2'd2; int_rst_en = 1'b1; cyc(600); int_rst_en = 1'b0; cyc(12);
    count_check("R2", "pulses at code 2 (P=256, 600 edges)", npulse, 2);
    clear_counts(); rate_sel = 2'd3; int_rst_en = 1'b1; cyc(2100); int_rst_en = 1'b0; cyc(12);
    count_check("R2", "pulses at code 3 (P=1024, 2100 edges)", npulse, 2);
    // R1: first pulse needs a full period after enable
    tag = "R1"; clear_counts(); rate_sel = 2'd0; int_rst_en = 1'b1; cyc(15); int_rst_en = 1'b0; cyc(300);
    count_check("R1", "pulses with enable short then low", npulse, 0);

    // R3/R4: single external request gives one 8-cycle pulse
    tag = "R3"; clear_counts(); ext_pulse(); cyc(15);
    count_check("R4", "pulses from one external request", npulse, 1);

    // R5: held external request; busy-time samples ignored
    tag = "R5"; clear_counts(); ext_rst_req = 1'b1; cyc(20); ext_rst_req = 1'b0; cyc(12);
    count_check("R5", "pulses from 20-cycle external hold", npulse, 3);
    // R5: internal and external on the same edge merge
    clear_counts(); int_rst_en = 1'b1; cyc(15); ext_pulse(); int_rst_en = 1'b0; cyc(12);
    count_check("R5", "pulses from coinciding requests", npulse, 1);

    // R6: arm then reset gives one strobe
    tag = "R6"; clear_counts(); cal_en = 1'b1; arm_pulse(); cyc(3); ext_pulse(); cyc(12);
    count_check("R6", "strobes after arm and reset", nstrobe, 1);
    // R6: reset with no arm gives none
    clear_counts(); ext_pulse(); cyc(12);
    count_check("R6", "strobes with no arm", nstrobe, 0);
    // R6: arm on accepting edge counts for the following reset
    clear_counts(); cal_arm = 1'b1; ext_rst_req = 1'b1; cyc(1); cal_arm = 1'b0; ext_rst_req = 1'b0;
    cyc(12); ext_pulse(); cyc(12);
    count_check("R6", "strobes with arm coinciding with reset", nstrobe, 1);

    // R7: two arms, two resets -> one strobe
    tag = "R7"; clear_counts(); arm_pulse(); cyc(2); arm_pulse(); cyc(2);
    ext_pulse(); cyc(12); ext_pulse(); cyc(12);
    count_check("R7", "strobes from two arms and two resets", nstrobe, 1);

    // R8: cal_en drop clears arm; arm ignored while disabled
    tag = "R8"; clear_counts(); arm_pulse(); cal_en = 1'b0; cyc(1); cal_en = 1'b1; ext_pulse(); cyc(12);
    count_check("R8", "strobes after enable dropped", nstrobe, 0);
    clear_counts(); cal_en = 1'b0; arm_pulse(); cal_en = 1'b1; cyc(2); ext_pulse(); cyc(12);
    count_check("R8", "strobes after arm while disabled", nstrobe, 0);

    // R9: reset mid-operation drops pulse and arm
    tag = "R9"; clear_counts(); arm_pulse(); ext_pulse(); cyc(2); rst = 1'b1; cyc(2);
    count_check("R9", "preamp_rst after mid-pulse reset", int'(preamp_rst), 0);
    rst = 1'b0; cyc(2); ext_pulse(); cyc(12);
    count_check("R9", "strobes after reset cleared arm", nstrobe, 1);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule